// File: doc/BRIEF.md
# Interrupt CPU Interface Arbiter

This block sits between an interrupt distributor and one processor core. From the distributor it takes, for every interrupt line, a pending flag, an enable flag, an 8-bit priority and a trigger type. It also keeps its own active flag for each line. Among the lines that are pending, enabled and not active, it picks the most urgent one. A lower priority value means more urgent, and equal values go to the lowest ID. The request line to the core is raised only when two things hold: the local enable bit is set, and the winner's priority value is strictly below the programmed priority mask.

Software works the block through a small word-addressed register port. A read of the acknowledge register returns the winning ID and marks that line active. A write of an ID to the completion register returns that line to inactive. A bypass bit, set at reset, hands the request line to an external bypass input until software clears it. When an edge-triggered line is acknowledged, the block sends a one-cycle clear pulse back to the distributor.

Top module: `irq_cpu_arbiter`

## Requirements
- R1: After reset, the enable bit is 0, the bypass bit is 1, the priority mask is 0x00, `reg_rdata_o` is 0 and `active_o` is all zero. With `bypass_irq_i` low, `irq_o` is 0.
- R2: The winner is the line with the lowest priority value among the lines that are pending, enabled and not active. Among lines with equal priority values, the lowest ID wins.
- R3: A winner qualifies only if its priority value is strictly less than the priority mask (register address 1, bits 7:0).
- R4: `irq_o` is driven only when the enable bit (address 0, bit 0) is 1. When the enable bit is 0, an acknowledge read returns 1023.
- R5: While the bypass bit (address 0, bit 1) is 1, `irq_o` equals `bypass_irq_i`. While it is 0, `irq_o` is the interface's own decision.
- R6: A read of address 2 puts the qualifying winner's ID in `reg_rdata_o` bits 9:0, with bits 31:10 zero, in the cycle after the read strobe. It also sets that line's `active_o` bit.
- R7: With no qualifying winner, a read of address 2 returns 1023 and leaves `active_o` unchanged.
- R8: Acknowledging a line whose `edge_i` bit is 1 pulses the matching bit of `clr_pend_o` for one cycle. Acknowledging a level line leaves `clr_pend_o` zero. At most one bit of `clr_pend_o` is ever set.
- R9: An active line takes no part in selection until it is completed. If it is still pending after completion, it competes again.
- R10: A write to address 3 with an active ID in bits 9:0 clears that line's active bit. An ID that is inactive or out of range changes nothing.
- R11: Addresses 0 and 1 read back as written, with unused bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | NUM_IRQ | Per-line pending flags from the distributor |
| en_i | input | NUM_IRQ | Per-line enable flags from the distributor |
| prio_i | input | NUM_IRQ*8 | Per-line priority, line i at bits 8i+7:8i |
| edge_i | input | NUM_IRQ | Per-line trigger type, 1 = edge |
| bypass_irq_i | input | 1 | Request forwarded while bypass is set |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Word address: 0 control, 1 mask, 2 acknowledge, 3 completion |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the strobe, held until the next read |
| irq_o | output | 1 | Request to the core |
| active_o | output | NUM_IRQ | Per-line active flags |
| clr_pend_o | output | NUM_IRQ | One-cycle pending-clear pulse for acknowledged edge lines |

## Verification
Some rules are checked by assertions on every cycle. A non-bypassed request never appears with the enable bit clear. A live acknowledge always returns an in-range ID with the upper bits zero. A spurious acknowledge leaves the active flags unchanged. A line is never acknowledged while it is already active. A completion naming an inactive line changes nothing. The clear pulse is at most one-hot. Other behaviour only the bench scenarios can show: which line wins under different pending, enable and mask patterns, ties, the strict mask boundary, a line competing again after completion, and bypass hand-over. Each of these depends on the exact ID returned over a sequence of register accesses.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int unsigned PRIO_W   = 8;
  localparam int unsigned ACK_W    = 10;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam logic [ACK_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_MASK = 2'd1,
    A_ACK  = 2'd2,
    A_EOI  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cpuif_prio_pick.sv
module cpuif_prio_pick
  import cpuif_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 16,
  localparam int unsigned ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0]        cand_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic                      win_valid_o,
  output logic [ID_W-1:0]           win_id_o,
  output logic [PRIO_W-1:0]         win_prio_o
);
  logic [PRIO_W-1:0] prio_arr [NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
    assign prio_arr[g] = prio_i[g*PRIO_W +: PRIO_W];
  end

  // Scan upward with strict compare so a tie keeps the lowest ID.
  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    win_prio_o  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand_i[i] && (!win_valid_o || prio_arr[i] < win_prio_o)) begin
        win_valid_o = 1'b1;
        win_id_o    = ID_W'(i);
        win_prio_o  = prio_arr[i];
      end
    end
  end
endmodule

// File: rtl/cpuif_regs.sv
module cpuif_regs
  import cpuif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [ACK_W-1:0]  ack_word_i,
  output logic              en_o,
  output logic              bypass_o,
  output logic [PRIO_W-1:0] mask_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] rd_mux;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[REG_W-1:PRIO_W];

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_CTRL:  rd_mux = {{(REG_W-2){1'b0}}, bypass_o, en_o};
      A_MASK:  rd_mux = {{(REG_W-PRIO_W){1'b0}}, mask_o};
      A_ACK:   rd_mux = {{(REG_W-ACK_W){1'b0}}, ack_word_i};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      bypass_o <= 1'b1;
      mask_o   <= '0;
      rdata_o  <= '0;
    end else begin
      if (wr_i && addr_i == A_CTRL) begin
        en_o     <= wdata_i[0];
        bypass_o <= wdata_i[1];
      end
      if (wr_i && addr_i == A_MASK) mask_o <= wdata_i[PRIO_W-1:0];
      if (rd_i) rdata_o <= rd_mux;
    end
  end

  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active
  import cpuif_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 16,
  localparam int unsigned ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  logic [ID_W-1:0]    set_id_i,
  input  logic               set_edge_i,
  input  logic               clr_en_i,
  input  logic [ACK_W-1:0]   clr_id_i,
  output logic [NUM_IRQ-1:0] active_o,
  output logic [NUM_IRQ-1:0] clr_pend_o
);
  logic [NUM_IRQ-1:0] set_hit, clr_hit;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign set_hit[g] = set_en_i && (set_id_i == ID_W'(g));
    assign clr_hit[g] = clr_en_i && (clr_id_i == ACK_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        active_o[g]   <= 1'b0;
        clr_pend_o[g] <= 1'b0;
      end else begin
        if (set_hit[g])      active_o[g] <= 1'b1;
        else if (clr_hit[g]) active_o[g] <= 1'b0;
        clr_pend_o[g] <= set_hit[g] && set_edge_i;
      end
    end
  end

  p_set_fresh_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |-> !active_o[set_id_i]);

  p_eoi_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !set_en_i && ((clr_hit & active_o) == '0)) |=> $stable(active_o));

  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_pend_o));
endmodule

// File: rtl/irq_cpu_arbiter.sv
module irq_cpu_arbiter
  import cpuif_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 16,
  localparam int unsigned ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_IRQ-1:0]        pend_i,
  input  logic [NUM_IRQ-1:0]        en_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [NUM_IRQ-1:0]        edge_i,
  input  logic                      bypass_irq_i,
  input  logic                      reg_wr_i,
  input  logic                      reg_rd_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [REG_W-1:0]          reg_wdata_i,
  output logic [REG_W-1:0]          reg_rdata_o,
  output logic                      irq_o,
  output logic [NUM_IRQ-1:0]        active_o,
  output logic [NUM_IRQ-1:0]        clr_pend_o
);
  logic [NUM_IRQ-1:0] cand;
  logic               win_valid;
  logic [ID_W-1:0]    win_id;
  logic [PRIO_W-1:0]  win_prio;
  logic               ctrl_en, ctrl_bypass;
  logic [PRIO_W-1:0]  mask;
  logic               signal;
  logic [ACK_W-1:0]   ack_word;
  logic               ack_take, eoi_wr;

  assign cand = pend_i & en_i & ~active_o;

  cpuif_prio_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .cand_i      (cand),
    .prio_i      (prio_i),
    .win_valid_o (win_valid),
    .win_id_o    (win_id),
    .win_prio_o  (win_prio)
  );

  assign signal   = ctrl_en && win_valid && (win_prio < mask);
  assign ack_word = signal ? ACK_W'(win_id) : SPURIOUS_ID;
  assign irq_o    = ctrl_bypass ? bypass_irq_i : signal;
  assign ack_take = reg_rd_i && (reg_addr_i == A_ACK) && signal;
  assign eoi_wr   = reg_wr_i && (reg_addr_i == A_EOI);

  cpuif_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .ack_word_i (ack_word),
    .en_o       (ctrl_en),
    .bypass_o   (ctrl_bypass),
    .mask_o     (mask),
    .rdata_o    (reg_rdata_o)
  );

  cpuif_active #(.NUM_IRQ(NUM_IRQ)) u_active (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (ack_take),
    .set_id_i   (win_id),
    .set_edge_i (edge_i[win_id]),
    .clr_en_i   (eoi_wr),
    .clr_id_i   (reg_wdata_i[ACK_W-1:0]),
    .active_o   (active_o),
    .clr_pend_o (clr_pend_o)
  );

  p_irq_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_bypass && irq_o) |-> ctrl_en);

  p_ack_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_take |=> (reg_rdata_o[ACK_W-1:0] < ACK_W'(NUM_IRQ)) &&
                 (reg_rdata_o[REG_W-1:ACK_W] == '0));

  p_spurious_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == A_ACK && !signal && !eoi_wr) |=>
      (reg_rdata_o == REG_W'(SPURIOUS_ID)) && $stable(active_o));
endmodule

// File: tb/irq_cpu_arbiter_test.sv
module irq_cpu_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pend = '0, en = '0, edg = '0;
  logic [N*8-1:0] prio;
  logic byp_irq = 0, wr = 0, rd = 0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  logic [N-1:0] active, clrp;
  int total = 0, bad = 0;

  irq_cpu_arbiter #(.NUM_IRQ(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
    .edge_i(edg), .bypass_irq_i(byp_irq), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .active_o(active), .clr_pend_o(clrp));

  always #(CLK_PERIOD/2) clk = ~clk;

  // line i priority: ((i*5)%8)<<4 -> 0:00 1:50 2:20 3:70 4:40 5:10 6:60 7:30, repeats for 8..15
  initial for (int i = 0; i < N; i++) prio[i*8 +: 8] = 8'(((i*5) % 8) << 4);

  // {pend, en, mask, expected ack id}
  localparam logic [49:0] VEC [11] = '{
    {16'h0006, 16'hFFFF, 8'hF0, 10'd2},
    {16'h0101, 16'hFFFF, 8'hF0, 10'd0},
    {16'h0100, 16'hFFFF, 8'hF0, 10'd8},
    {16'h00A8, 16'hFFFF, 8'hF0, 10'd5},
    {16'h00A8, 16'hFFDF, 8'hF0, 10'd7},
    {16'h0008, 16'hFFFF, 8'h70, 10'd1023},
    {16'h0008, 16'hFFFF, 8'h71, 10'd3},
    {16'h0000, 16'hFFFF, 8'hF0, 10'd1023},
    {16'hFFFF, 16'h0000, 8'hF0, 10'd1023},
    {16'h8040, 16'hFFFF, 8'hF0, 10'd15},
    {16'h2020, 16'hFFFF, 8'hF0, 10'd5}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a);
    rd = 1; addr = a;
    @(negedge clk);
    rd = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    chk(active == 0, "R1 active", 32'(active), 0);
    chk(rdata == 0, "R1 rdata", rdata, 0);
    rreg(0); chk(rdata == 32'h2, "R1 ctrl", rdata, 32'h2);
    rreg(1); chk(rdata == 0, "R1 mask", rdata, 0);

    // R5 bypass follows input
    byp_irq = 1; #1;
    chk(irq == 1, "R5 bypass high", 32'(irq), 1);
    byp_irq = 0; #1;
    chk(irq == 0, "R5 bypass low", 32'(irq), 0);

    // R4 enable off: winner exists but no signal, spurious ack
    wreg(1, 32'hFF); wreg(0, 32'h0);
    pend = 16'h0001; en = '1;
    @(negedge clk);
    chk(irq == 0, "R4 gated irq", 32'(irq), 0);
    rreg(2); chk(rdata == 1023, "R4 spurious when disabled", rdata, 1023);
    chk(active == 0, "R4 active", 32'(active), 0);

    // R11 readback
    wreg(0, 32'hFFFF_FFFD);
    rreg(0); chk(rdata == 32'h1, "R11 ctrl", rdata, 1);
    wreg(1, 32'h1234_56F0);
    rreg(1); chk(rdata == 32'hF0, "R11 mask", rdata, 32'hF0);
    byp_irq = 1; #1;
    chk(irq == 1, "R5 own decision with bypass clear", 32'(irq), 1);
    byp_irq = 0;

    // R2 R3 R6 R7 vector walk
    for (int v = 0; v < 11; v++) begin
      logic [9:0] exp_id;
      exp_id = VEC[v][9:0];
      pend = VEC[v][49:34]; en = VEC[v][33:18];
      wreg(1, {24'h0, VEC[v][17:10]});
      chk(irq == (exp_id != 1023), "R2/R3 irq vec", 32'(irq), 32'(exp_id != 1023));
      rreg(2);
      chk(rdata == {22'h0, exp_id}, "R2 R3 R6 ack id", rdata, {22'h0, exp_id});
      if (exp_id != 1023) begin
        chk(active == (16'h1 << exp_id), "R6 active set", 32'(active), 32'(16'h1 << exp_id));
        chk(clrp == 0, "R8 level no clear", 32'(clrp), 0);
        wreg(3, {22'h0, exp_id});
        chk(active == 0, "R10 eoi clears", 32'(active), 0);
      end else begin
        chk(active == 0, "R7 spurious no change", 32'(active), 0);
      end
    end

    // R8 edge line acknowledge
    wreg(1, 32'hF0);
    pend = 16'h0010; edg = 16'h0010;
    @(negedge clk);
    rreg(2);
    chk(rdata == 4, "R8 edge ack id", rdata, 4);
    chk(clrp == 16'h0010, "R8 clear pulse", 32'(clrp), 32'h10);
    pend = 0;
    @(negedge clk);
    chk(clrp == 0, "R8 pulse one cycle", 32'(clrp), 0);
    wreg(3, 4); edg = 0;

    // R9 active line excluded until completed
    pend = 16'h0006;
    @(negedge clk);
    rreg(2); chk(rdata == 2, "R9 first ack", rdata, 2);
    chk(irq == 1, "R9 next line still signalled", 32'(irq), 1);
    rreg(2); chk(rdata == 1, "R9 second ack skips active", rdata, 1);
    chk(irq == 0, "R9 no signal while both active", 32'(irq), 0);
    rreg(2); chk(rdata == 1023, "R9 spurious while active", rdata, 1023);
    // R10 ignored completions
    wreg(3, 9);
    chk(active == 16'h0006, "R10 inactive id ignored", 32'(active), 32'h6);
    wreg(3, 1000);
    chk(active == 16'h0006, "R10 out of range ignored", 32'(active), 32'h6);
    wreg(2, 2);
    chk(active == 16'h0006, "R10 write to ack ignored", 32'(active), 32'h6);
    wreg(3, 2);
    chk(active == 16'h0002, "R10 eoi clears one", 32'(active), 32'h2);
    chk(irq == 1, "R9 resignal after completion", 32'(irq), 1);
    rreg(2); chk(rdata == 2, "R9 reack after completion", rdata, 2);
    wreg(3, 2); wreg(3, 1);
    chk(active == 0, "R10 all clear", 32'(active), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule